// File: doc/BRIEF.md
# Address Decoder Commit Register Bank

This block holds a bank of memory-range decoder register sets behind a plain 32-bit register read/write port. Every decoder keeps a 64-bit base, a 64-bit size, a control word and one 64-bit auxiliary pair. In the switch flavour the auxiliary pair is a target list: eight 8-bit port identifiers, the one for way k in byte k, of which only the first "ways" bytes carry meaning. In the endpoint flavour the same pair holds a 64-bit skip amount. A read-only capability word tells software how many decoders exist, how many targets a list holds and which optional interleave counts are available.

Software fills in the fields and then raises the commit bit. The decoder does not simply accept the values. It starts a validation window of `COMMIT_CYCLES` clock cycles, which stands for the hardware response bound. At the end of the window it reports either committed or commit error. A commit succeeds only if the previous decoder is already committed when the request arrives, the interleave setting is allowed, the granularity code is in range and the size is non-zero and an exact multiple of the way count. When the commit bit is cleared the decoder returns to idle. Once a decoder is committed its configuration is frozen. If it is also locked, even its control word is frozen until reset. Routing of transactions is outside this block.

Each decoder runs a four-state machine. `ST_IDLE` moves to `ST_CHECK` on a rising commit bit. `ST_CHECK` moves to `ST_ACTIVE` when the window ends with a passing verdict, to `ST_FAULT` when it ends with a failing one, and back to `ST_IDLE` if the commit bit is cleared before the window ends. `ST_ACTIVE` and `ST_FAULT` both return to `ST_IDLE` when the commit bit is cleared. Clearing is not accepted in `ST_ACTIVE` while the decoder is locked.

Top module: `range_decoder_bank`

## Requirements
- R1: After reset, every decoder register reads 0, including control, base, size and the auxiliary pair.
- R2: Word address 8*(d+1)+r selects register r of decoder d: r=0 base low, r=1 base high, r=2 size low, r=3 size high, r=4 control, r=5 auxiliary low, r=6 auxiliary high. While a decoder is idle, writes to r in {0,1,2,3,5,6} read back unchanged.
- R3: Control bits are: bit 0 commit request, bit 1 lock, bit 2 host-only type, bit 3 committed (read-only), bit 4 commit error (read-only), bits 11:8 ways code, bits 15:12 granularity code. After a write that raises bit 0, status is still clear COMMIT_CYCLES-1 cycles later and bit 3 or bit 4 is set after COMMIT_CYCLES cycles.
- R4: A commit of decoder d>0 that starts while decoder d-1 is not committed ends with commit error. A commit that starts while decoder d-1 is committed can succeed.
- R5: Ways codes 0 to 4 mean 1, 2, 4, 8 and 16 ways, and codes 8, 9 and 10 mean 3, 6 and 12 ways. Codes 0 to 3 are always legal. Codes 8 to 10 need the 3/6/12-way capability, code 4 needs the 16-way capability, and no way count may exceed the target count in the switch flavour. Every other code, or a missing capability, gives commit error.
- R6: A granularity code above 6 (256 bytes shifted left by the code) gives commit error. Code 6 is accepted.
- R7: A size of zero, or a size that is not an exact multiple of the way count, gives commit error. Both 32-bit halves of the size take part in the check.
- R8: Writing control with bit 0 clear to a committed or faulted decoder clears bits 3 and 4. A decoder that has been cleared from committed keeps its ways and granularity fields until the next write.
- R9: While a decoder is committed, writes to its base, size and auxiliary registers, and to its host-only, ways and granularity fields, are ignored.
- R10: While a committed decoder has its lock bit set, every write to its control word is ignored, so it stays committed.
- R11: Word address 0 is a read-only capability word: bits 3:0 decoder count, bits 7:4 target count (8 for switch, 0 for endpoint), bit 8 3/6/12-way support, bit 9 16-way support, bit 10 endpoint flavour. Writes to it have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe for the addressed word |
| reg_addr | input | ADDR_W | Word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |

## Verification
A decoder whose state machine is left in the wrong state shows it in the control word. A missing or early committed bit appears exactly at the cycle COMMIT_CYCLES after the request, which the bench samples on both sides. A wrong verdict appears as the opposite status bit at that same cycle. Lost freezing or locking is visible on the next read of the register that was written. A broken ordering flag shows only when the next decoder in the chain commits, so the bench commits decoders both with and without a committed predecessor.

// File: rtl/rdb_pkg.sv
package rdb_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_CHECK,
        ST_ACTIVE,
        ST_FAULT
    } commit_st_e;

    // control word bit positions
    localparam int CTL_COMMIT   = 0;
    localparam int CTL_LOCK     = 1;
    localparam int CTL_HOST     = 2;
    localparam int CTL_DONE     = 3;
    localparam int CTL_ERR      = 4;
    localparam int CTL_WAYS_LSB = 8;
    localparam int CTL_GRAN_LSB = 12;

    // register index inside one decoder window
    localparam logic [2:0] RG_BASE_LO = 3'd0;
    localparam logic [2:0] RG_BASE_HI = 3'd1;
    localparam logic [2:0] RG_SIZE_LO = 3'd2;
    localparam logic [2:0] RG_SIZE_HI = 3'd3;
    localparam logic [2:0] RG_CTRL    = 3'd4;
    localparam logic [2:0] RG_AUX_LO  = 3'd5;
    localparam logic [2:0] RG_AUX_HI  = 3'd6;

    localparam logic [3:0] GRAN_MAX = 4'd6;

    // residue modulo 3: 4 == 1 (mod 3), so sum the 2-bit digits
    function automatic logic [1:0] mod3_64(input logic [63:0] v);
        logic [7:0] s;
        s = 8'd0;
        for (int k = 0; k < 32; k++) begin
            s = s + 8'(v[2*k +: 2]);
        end
        return 2'(s % 8'd3);
    endfunction

    function automatic logic ways_legal(input logic [3:0] code,
                                        input logic cap3,
                                        input logic cap16,
                                        input int max_ways);
        case (code)
            4'd0, 4'd1, 4'd2: return 1'b1;
            4'd3:  return max_ways >= 8;
            4'd4:  return cap16 && (max_ways >= 16);
            4'd8:  return cap3 && (max_ways >= 3);
            4'd9:  return cap3 && (max_ways >= 6);
            4'd10: return cap3 && (max_ways >= 12);
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic ways_divides(input logic [3:0] code,
                                          input logic [63:0] size);
        case (code)
            4'd0, 4'd1, 4'd2, 4'd3, 4'd4:
                return (size & ((64'd1 << code) - 64'd1)) == 64'd0;
            4'd8:  return mod3_64(size) == 2'd0;
            4'd9:  return !size[0] && (mod3_64(size) == 2'd0);
            4'd10: return (size[1:0] == 2'b00) && (mod3_64(size) == 2'd0);
            default: return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/rdb_cfg_check.sv
module rdb_cfg_check
    import rdb_pkg::*;
#(
    parameter bit CAP_3WAY  = 1'b1,
    parameter bit CAP_16WAY = 1'b0,
    parameter int MAX_WAYS  = 8
) (
    input  logic [3:0]  ways_code,
    input  logic [3:0]  gran_code,
    input  logic [63:0] size,
    output logic        cfg_ok
);

    logic ways_ok;
    logic gran_ok;
    logic size_ok;

    always_comb begin
        ways_ok = ways_legal(ways_code, CAP_3WAY, CAP_16WAY, MAX_WAYS);
        gran_ok = gran_code <= GRAN_MAX;
        size_ok = (size != 64'd0) && ways_divides(ways_code, size);
        cfg_ok  = ways_ok && gran_ok && size_ok;
    end

endmodule

// File: rtl/rdb_commit_fsm.sv
module rdb_commit_fsm
    import rdb_pkg::*;
#(
    parameter int COMMIT_CYCLES = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_rise,
    input  logic req_clear,
    input  logic order_ok,
    input  logic cfg_ok,
    output logic committed,
    output logic error,
    output logic cfg_open
);

    localparam int            CW       = $clog2(COMMIT_CYCLES + 1);
    localparam logic [CW-1:0] CNT_LOAD = CW'(COMMIT_CYCLES - 1);

    commit_st_e    state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic          order_q, order_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            order_q <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            order_q <= order_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        order_d = order_q;
        unique case (state_q)
            ST_IDLE: begin
                if (req_rise) begin
                    state_d = ST_CHECK;
                    cnt_d   = CNT_LOAD;
                    order_d = order_ok;
                end
            end
            ST_CHECK: begin
                if (req_clear) begin
                    state_d = ST_IDLE;
                end else if (cnt_q == '0) begin
                    state_d = (order_q && cfg_ok) ? ST_ACTIVE : ST_FAULT;
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            ST_ACTIVE: begin
                if (req_clear) state_d = ST_IDLE;
            end
            ST_FAULT: begin
                if (req_clear) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        committed = (state_q == ST_ACTIVE);
        error     = (state_q == ST_FAULT);
        cfg_open  = (state_q == ST_IDLE) || (state_q == ST_FAULT);
    end

endmodule

// File: rtl/rdb_slot.sv
module rdb_slot
    import rdb_pkg::*;
#(
    parameter int COMMIT_CYCLES = 8,
    parameter bit CAP_3WAY      = 1'b1,
    parameter bit CAP_16WAY     = 1'b0,
    parameter int MAX_WAYS      = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [2:0]  sel,
    input  logic [31:0] wdata,
    input  logic        prev_committed,
    output logic [31:0] rdata,
    output logic        committed,
    output logic        commit_req,
    output logic        locked,
    output logic [63:0] base,
    output logic [63:0] size,
    output logic [3:0]  ways
);

    logic [63:0] base_q, size_q, aux_q;
    logic        commit_q, lock_q, host_q;
    logic [3:0]  ways_q, gran_q;

    logic error, cfg_open, cfg_ok;
    logic ctrl_wr, field_wr, req_rise, req_clear;

    rdb_cfg_check #(
        .CAP_3WAY (CAP_3WAY),
        .CAP_16WAY(CAP_16WAY),
        .MAX_WAYS (MAX_WAYS)
    ) i_check (
        .ways_code(ways_q),
        .gran_code(gran_q),
        .size     (size_q),
        .cfg_ok   (cfg_ok)
    );

    rdb_commit_fsm #(
        .COMMIT_CYCLES(COMMIT_CYCLES)
    ) i_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_rise (req_rise),
        .req_clear(req_clear),
        .order_ok (prev_committed),
        .cfg_ok   (cfg_ok),
        .committed(committed),
        .error    (error),
        .cfg_open (cfg_open)
    );

    always_comb begin
        ctrl_wr   = wr_en && (sel == RG_CTRL) && !(committed && lock_q);
        field_wr  = wr_en && cfg_open;
        req_rise  = ctrl_wr && wdata[CTL_COMMIT] && !commit_q;
        req_clear = ctrl_wr && !wdata[CTL_COMMIT] && commit_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q   <= '0;
            size_q   <= '0;
            aux_q    <= '0;
            commit_q <= 1'b0;
            lock_q   <= 1'b0;
            host_q   <= 1'b0;
            ways_q   <= '0;
            gran_q   <= '0;
        end else begin
            if (field_wr) begin
                case (sel)
                    RG_BASE_LO: base_q[31:0]  <= wdata;
                    RG_BASE_HI: base_q[63:32] <= wdata;
                    RG_SIZE_LO: size_q[31:0]  <= wdata;
                    RG_SIZE_HI: size_q[63:32] <= wdata;
                    RG_AUX_LO:  aux_q[31:0]   <= wdata;
                    RG_AUX_HI:  aux_q[63:32]  <= wdata;
                    default: ;
                endcase
            end
            if (ctrl_wr) begin
                commit_q <= wdata[CTL_COMMIT];
                lock_q   <= wdata[CTL_LOCK];
                if (cfg_open) begin
                    host_q <= wdata[CTL_HOST];
                    ways_q <= wdata[CTL_WAYS_LSB +: 4];
                    gran_q <= wdata[CTL_GRAN_LSB +: 4];
                end
            end
        end
    end

    always_comb begin
        case (sel)
            RG_BASE_LO: rdata = base_q[31:0];
            RG_BASE_HI: rdata = base_q[63:32];
            RG_SIZE_LO: rdata = size_q[31:0];
            RG_SIZE_HI: rdata = size_q[63:32];
            RG_CTRL:    rdata = {16'd0, gran_q, ways_q, 3'd0,
                                 error, committed, host_q, lock_q, commit_q};
            RG_AUX_LO:  rdata = aux_q[31:0];
            RG_AUX_HI:  rdata = aux_q[63:32];
            default:    rdata = 32'd0;
        endcase
    end

    assign commit_req = commit_q;
    assign locked     = lock_q;
    assign base       = base_q;
    assign size       = size_q;
    assign ways       = ways_q;

endmodule

// File: rtl/range_decoder_bank.sv
module range_decoder_bank
    import rdb_pkg::*;
#(
    parameter int NUM_DEC       = 4,
    parameter int COMMIT_CYCLES = 8,
    parameter bit ENDPOINT      = 1'b0,
    parameter bit CAP_3WAY      = 1'b1,
    parameter bit CAP_16WAY     = 1'b0,
    parameter int ADDR_W        = $clog2(8 * (NUM_DEC + 1))
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata
);

    localparam int BW        = ADDR_W - 3;
    localparam int TGT_COUNT = ENDPOINT ? 0 : 8;
    localparam int MAX_WAYS  = ENDPOINT ? 16 : TGT_COUNT;
    localparam logic [31:0] CAP_WORD = {21'd0, ENDPOINT, CAP_16WAY, CAP_3WAY,
                                        4'(TGT_COUNT), 4'(NUM_DEC)};

    logic [BW-1:0] blk;
    logic [2:0]    sel;

    logic [NUM_DEC-1:0]       dec_committed;
    logic [NUM_DEC-1:0]       dec_req;
    logic [NUM_DEC-1:0]       dec_lock;
    logic [NUM_DEC-1:0][63:0] dec_base;
    logic [NUM_DEC-1:0][63:0] dec_size;
    logic [NUM_DEC-1:0][3:0]  dec_ways;
    logic [31:0]              slot_rdata [NUM_DEC];

    assign blk = reg_addr[ADDR_W-1:3];
    assign sel = reg_addr[2:0];

    for (genvar i = 0; i < NUM_DEC; i++) begin : g_slot
        logic wr_hit;
        logic prev_ok;

        assign wr_hit = reg_wr && (blk == BW'(i + 1));

        if (i == 0) begin : g_first
            assign prev_ok = 1'b1;
        end else begin : g_chain
            assign prev_ok = dec_committed[i-1];
        end

        rdb_slot #(
            .COMMIT_CYCLES(COMMIT_CYCLES),
            .CAP_3WAY     (CAP_3WAY),
            .CAP_16WAY    (CAP_16WAY),
            .MAX_WAYS     (MAX_WAYS)
        ) i_slot (
            .clk           (clk),
            .rst_n         (rst_n),
            .wr_en         (wr_hit),
            .sel           (sel),
            .wdata         (reg_wdata),
            .prev_committed(prev_ok),
            .rdata         (slot_rdata[i]),
            .committed     (dec_committed[i]),
            .commit_req    (dec_req[i]),
            .locked        (dec_lock[i]),
            .base          (dec_base[i]),
            .size          (dec_size[i]),
            .ways          (dec_ways[i])
        );
    end

    always_comb begin
        reg_rdata = 32'd0;
        if (blk == '0) begin
            if (sel == 3'd0) reg_rdata = CAP_WORD;
        end else begin
            for (int i = 0; i < NUM_DEC; i++) begin
                if (blk == BW'(i + 1)) reg_rdata = slot_rdata[i];
            end
        end
    end

endmodule

// File: rtl/rdb_bank_chk.sv
module rdb_bank_chk #(
    parameter int NUM_DEC = 4
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic [NUM_DEC-1:0]       committed,
    input logic [NUM_DEC-1:0]       req,
    input logic [NUM_DEC-1:0]       lock,
    input logic [NUM_DEC-1:0][63:0] base,
    input logic [NUM_DEC-1:0][63:0] size,
    input logic [NUM_DEC-1:0][3:0]  ways
);

    for (genvar i = 0; i < NUM_DEC; i++) begin : g_chk
        AST_DONE_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
            committed[i] |-> req[i]); // R8
        AST_LOCK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
            (committed[i] && lock[i]) |=> committed[i]); // R10
        AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
            committed[i] |=> ($stable(base[i]) && $stable(size[i]) && $stable(ways[i]))); // R9
        AST_NONZERO_SIZE: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(committed[i]) |-> (size[i] != 64'd0)); // R7
        AST_WAYS_KNOWN: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(committed[i]) |-> ((ways[i] <= 4'd4) || ((ways[i] >= 4'd8) && (ways[i] <= 4'd10)))); // R5
    end

endmodule

bind range_decoder_bank rdb_bank_chk #(.NUM_DEC(NUM_DEC)) i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .committed(dec_committed),
    .req      (dec_req),
    .lock     (dec_lock),
    .base     (dec_base),
    .size     (dec_size),
    .ways     (dec_ways)
);

// File: tb/test_range_decoder_bank.sv
module test_range_decoder_bank;

    localparam int C = 8;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        reg_wr;
    logic [5:0]  reg_addr;
    logic [31:0] reg_wdata;
    logic [31:0] reg_rdata;

    int errors = 0;
    int checks = 0;

    always #4 clk = ~clk;

    range_decoder_bank #(
        .NUM_DEC(4), .COMMIT_CYCLES(C), .ENDPOINT(1'b0),
        .CAP_3WAY(1'b1), .CAP_16WAY(1'b0)
    ) i_range_decoder_bank (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
    );

    function automatic int adr(input int slot, input int r);
        return 8 * (slot + 1) + r;
    endfunction

    function automatic logic [31:0] ctl(input bit c, input bit lk,
                                        input int w, input int g);
        return 32'(c) | (32'(lk) << 1) | (32'(w) << 8) | (32'(g) << 12);
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        reg_addr  = 6'(a);
        reg_wdata = d;
        reg_wr    = 1'b1;
        @(negedge clk);
        reg_wr    = 1'b0;
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        reg_addr = 6'(a);
        #1;
        d = reg_rdata;
    endtask

    task automatic expect_rd(input string tag, input int a, input logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        chk(tag, v, exp);
    endtask

    // commit with a given size/ways/gran, check verdict, then clear twice
    task automatic try_commit(input string tag, input int slot, input logic [63:0] sz,
                              input int w, input int g, input bit ok);
        logic [31:0] c;
        c = ctl(1, 0, w, g);
        wr(adr(slot, 2), sz[31:0]);
        wr(adr(slot, 3), sz[63:32]);
        wr(adr(slot, 4), c);
        repeat (C) @(negedge clk);
        expect_rd(tag, adr(slot, 4), c | (ok ? 32'h8 : 32'h10));
        wr(adr(slot, 4), 32'd0);
        expect_rd({tag, " R8 clear"}, adr(slot, 4), ok ? (c & 32'hFFFF_FFFE) : 32'd0);
        wr(adr(slot, 4), 32'd0);
        expect_rd({tag, " R8 idle"}, adr(slot, 4), 32'd0);
    endtask

    task automatic t_reset;
        expect_rd("R11 capability word", 0, 32'h0000_0184);
        expect_rd("R1 ctrl slot0", adr(0, 4), 32'd0);
        expect_rd("R1 base slot3", adr(3, 0), 32'd0);
        expect_rd("R1 size hi slot2", adr(2, 3), 32'd0);
        expect_rd("R1 aux hi slot1", adr(1, 6), 32'd0);
        wr(0, 32'hFFFF_FFFF);
        expect_rd("R11 capability write ignored", 0, 32'h0000_0184);
    endtask

    task automatic t_readback;
        for (int r = 0; r < 7; r++) begin
            if (r != 4) wr(adr(3, r), 32'hA500_0000 + 32'(r * 17));
        end
        for (int r = 0; r < 7; r++) begin
            if (r != 4) expect_rd("R2 readback", adr(3, r), 32'hA500_0000 + 32'(r * 17));
        end
    endtask

    task automatic t_commit_timing;
        wr(adr(0, 0), 32'h4000_0000);
        wr(adr(0, 2), 32'h0000_1000);
        wr(adr(0, 4), ctl(1, 0, 1, 0));
        repeat (C - 1) @(negedge clk);
        expect_rd("R3 before window end", adr(0, 4), 32'h0000_0101);
        @(negedge clk);
        expect_rd("R3 committed at window end", adr(0, 4), 32'h0000_0109);
    endtask

    task automatic t_frozen;
        wr(adr(0, 0), 32'h0000_DEAD);
        wr(adr(0, 2), 32'h0000_2000);
        wr(adr(0, 5), 32'h0000_0055);
        wr(adr(0, 4), ctl(1, 0, 2, 3) | 32'h4);
        expect_rd("R9 base frozen", adr(0, 0), 32'h4000_0000);
        expect_rd("R9 size frozen", adr(0, 2), 32'h0000_1000);
        expect_rd("R9 aux frozen", adr(0, 5), 32'd0);
        expect_rd("R9 ctrl fields frozen", adr(0, 4), 32'h0000_0109);
    endtask

    task automatic t_order;
        wr(adr(2, 2), 32'h0000_0100);
        wr(adr(2, 4), ctl(1, 0, 0, 0));
        repeat (C) @(negedge clk);
        expect_rd("R4 out of order error", adr(2, 4), 32'h0000_0011);
        wr(adr(2, 4), 32'd0);
        expect_rd("R8 error cleared", adr(2, 4), 32'd0);
    endtask

    task automatic t_ways;
        try_commit("R5 code 5 illegal", 1, 64'h1000, 5, 0, 1'b0);
        try_commit("R5 16-way without capability", 1, 64'h10000, 4, 0, 1'b0);
        try_commit("R5 12-way over target count", 1, 64'h3000, 10, 0, 1'b0);
        try_commit("R5 6-way legal", 1, 64'h600, 9, 0, 1'b1);
        try_commit("R5 8-way legal", 1, 64'h800, 3, 0, 1'b1);
    endtask

    task automatic t_gran;
        try_commit("R6 granularity 7", 1, 64'h100, 0, 7, 1'b0);
        try_commit("R6 granularity 6", 1, 64'h100, 0, 6, 1'b1);
    endtask

    task automatic t_size;
        try_commit("R7 zero size", 1, 64'h0, 0, 0, 1'b0);
        try_commit("R7 odd size 2-way", 1, 64'h1001, 1, 0, 1'b0);
        try_commit("R7 size not multiple of 3", 1, 64'h800, 8, 0, 1'b0);
        try_commit("R7 size multiple of 3", 1, 64'h300, 8, 0, 1'b1);
        try_commit("R7 size in high half", 1, 64'h1_0000_0000, 0, 0, 1'b1);
    endtask

    task automatic t_lock;
        wr(adr(1, 0), 32'h0000_7000);
        wr(adr(1, 2), 32'h0000_1000);
        wr(adr(1, 3), 32'd0);
        wr(adr(1, 4), ctl(1, 1, 0, 0));
        repeat (C) @(negedge clk);
        expect_rd("R10 locked commit", adr(1, 4), 32'h0000_000B);
        wr(adr(1, 4), 32'd0);
        repeat (C) @(negedge clk);
        expect_rd("R10 clear ignored while locked", adr(1, 4), 32'h0000_000B);
        wr(adr(1, 0), 32'h0000_1234);
        expect_rd("R10 base kept while locked", adr(1, 0), 32'h0000_7000);
        wr(adr(2, 2), 32'h0000_0100);
        wr(adr(2, 4), ctl(1, 0, 0, 0));
        repeat (C) @(negedge clk);
        expect_rd("R4 in-order commit succeeds", adr(2, 4), 32'h0000_0009);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        rst_n     = 1'b0;
        reg_wr    = 1'b0;
        reg_addr  = '0;
        reg_wdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_readback();
        t_commit_timing();
        t_frozen();
        t_order();
        t_ways();
        t_gran();
        t_size();
        t_lock();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule